// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves the core from one operating point, a supply voltage code paired with a clock ratio, to another. Software writes a target voltage code and ratio with a one-cycle strobe. The sequencer then drives the supply code one step at a time and asks the PLL to relock. It waits for the PLL's lock acknowledge and pulses `done` once the new point is fully in place. The order of the two changes depends on the direction. A faster ratio needs the voltage raised first and the clock changed after it. A slower ratio has the clock changed first and the voltage lowered afterwards.

While the PLL relocks, the core is marked unavailable and snooping on the system bus is blocked. That window has a hard limit in cycles. If the PLL has not locked by the limit, both signals are released and the sequencer keeps waiting for the lock without them. A write that arrives while a transition runs is not lost. It is parked in a one-deep holding register, where a later write replaces an earlier unserved one, and it starts as soon as the running transition ends. A target equal to the present point completes at once.

Top module: `vfs_seq`

## Requirements
- R1: When the requested ratio is higher than `ratio_out`, the sequencer first brings `vid_out` to the requested code. Only then does it raise `pll_relock` for one cycle, and `ratio_out` takes the new ratio in that same cycle.
- R2: When the requested ratio is lower than `ratio_out`, `pll_relock` and the new `ratio_out` come first, while `vid_out` still holds the code it had at acceptance. `vid_out` moves toward the target only after the lock has been accepted.
- R3: When the requested ratio equals `ratio_out` but the code differs, only `vid_out` is stepped, and `pll_relock` is never raised.
- R4: `vid_out` changes by exactly +1 or -1 when it moves, and it moves once every `STEP_DWELL` cycles while stepping.
- R5: `core_hold` and `snoop_block` are high from the `pll_relock` cycle until the lock is accepted, for at most `HOLD_MAX` cycles. If that limit is reached, both drop and the sequencer keeps waiting for `pll_lock` with `busy` still high.
- R6: `pll_lock` has no effect in the first cycle of a relock, nor at any time when no relock is outstanding.
- R7: A write made while `busy` is high is deferred and starts when the running transition ends. If several writes arrive during one transition, only the newest is carried out.
- R8: A write whose code and ratio both equal `vid_out` and `ratio_out` gives a `done` pulse in the next cycle. `busy` and `pll_relock` stay low and neither output changes.
- R9: `done` is a one-cycle pulse with `busy` low, and in that cycle `vid_out` and `ratio_out` equal the accepted target.
- R10: After reset, `vid_out` equals `VID_INIT` and `ratio_out` equals `RATIO_INIT`, and `busy`, `done`, `pll_relock`, `core_hold` and `snoop_block` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle write strobe of a new target |
| req_vid | input | VID_W | Requested voltage code |
| req_ratio | input | RATIO_W | Requested clock ratio |
| pll_lock | input | 1 | Lock acknowledge from the PLL |
| vid_out | output | VID_W | Voltage code driven to the regulator |
| ratio_out | output | RATIO_W | Clock ratio applied to the PLL |
| pll_relock | output | 1 | One-cycle relock request |
| core_hold | output | 1 | Core unavailable during relock |
| snoop_block | output | 1 | Bus snoop block during relock |
| busy | output | 1 | A transition is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sequencer is driven through four patterns, each of which separates the direction rules:
- a ratio increase, which must show the voltage reaching its target before the relock;
- a ratio decrease, which must show the relock while the voltage is unchanged;
- a ratio kept while the code changes, which must show no relock at all;
- a target equal to the present point, which must show an immediate `done` with no motion.

A burst of three writes during one transition checks that only the newest deferred target is carried out. Stray lock pulses while idle or stepping check that no lock is taken outside a relock. A PLL that locks late checks that the hold window ends at its limit while the transition still completes.

// File: rtl/vfs_pkg.sv
// Package: shared phase encoding of the transition sequencer.
// Assumes: used by vfs_seq only; no widths live here, they are module parameters.
package vfs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,   // waiting for a target
        PH_VOLT     = 2'd1,   // stepping the voltage code
        PH_CLK      = 2'd2,   // relock in progress, core held
        PH_CLK_LATE = 2'd3    // hold window spent, still waiting for lock
    } vfs_phase_e;

endpackage

// File: rtl/vfs_req_hold.sv
// Module: one-deep holding register for targets written during a transition.
// Does:    stores a write made while the sequencer is busy; newer writes
//          overwrite older unserved ones; cleared when the idle sequencer
//          takes a target.
// Assumes: 'take' is high only while the sequencer is idle.
module vfs_req_hold #(
    parameter int VID_W   = 6,
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [VID_W-1:0]   wr_vid,
    input  logic [RATIO_W-1:0] wr_ratio,
    input  logic               defer,
    input  logic               take,
    output logic               pend_v,
    output logic [VID_W-1:0]   pend_vid,
    output logic [RATIO_W-1:0] pend_ratio
);

    // Capture a deferred write, newest wins; drop it once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_vid   <= '0;
            pend_ratio <= '0;
        end else if (wr && defer) begin
            pend_v     <= 1'b1;
            pend_vid   <= wr_vid;
            pend_ratio <= wr_ratio;
        end else if (take) begin
            pend_v     <= 1'b0;
        end
    end

endmodule

// File: rtl/vfs_vid_stepper.sv
// Module: voltage code ramp.
// Does:    holds the voltage code and, while enabled, moves it one unit
//          toward the target after each dwell of STEP_DWELL cycles.
// Assumes: the target is stable while enabled; at_tgt is combinational.
module vfs_vid_stepper #(
    parameter int VID_W      = 6,
    parameter int STEP_DWELL = 3,
    parameter int VID_INIT   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VID_W-1:0] tgt,
    output logic [VID_W-1:0] vid,
    output logic             at_tgt
);

    localparam int CNT_W = (STEP_DWELL > 1) ? $clog2(STEP_DWELL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_DWELL - 1);
    localparam logic [VID_W-1:0] INIT = VID_W'(VID_INIT);

    logic [CNT_W-1:0] dwell_q;

    // Target reached when the held code equals the requested one.
    always_comb at_tgt = (vid == tgt);

    // Dwell counter and single-unit move of the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid     <= INIT;
            dwell_q <= '0;
        end else if (!en || at_tgt) begin
            dwell_q <= '0;
        end else if (dwell_q == LAST) begin
            dwell_q <= '0;
            vid     <= (tgt > vid) ? vid + 1'b1 : vid - 1'b1;
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

endmodule

// File: rtl/vfs_relock_timer.sv
// Module: relock window timer.
// Does:    counts cycles spent in the relock phase; flags the first cycle
//          (relock request) and the last allowed cycle of the hold window.
// Assumes: en drops on the cycle after 'expired' is acted upon.
module vfs_relock_timer #(
    parameter int HOLD_MAX = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic first,
    output logic expired
);

    localparam int CNT_W = $clog2(HOLD_MAX + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_MAX - 1);

    logic [CNT_W-1:0] cnt_q;

    // Elapsed relock cycles, cleared outside the relock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Decode of the first and last window cycles.
    always_comb begin
        first   = en && (cnt_q == '0);
        expired = en && (cnt_q == LAST);
    end

endmodule

// File: rtl/vfs_seq.sv
// Module: operating point transition sequencer (top).
// Does:    accepts a target voltage code and ratio; raises voltage before
//          a ratio increase and lowers it after a ratio decrease; requests
//          a PLL relock and holds the core and blocks snoops until lock or
//          until HOLD_MAX cycles pass; defers writes made while busy.
// Assumes: pll_lock is an acknowledge pulse or level from the PLL model;
//          the register decode delivers req_valid as a one-cycle strobe.
module vfs_seq
    import vfs_pkg::*;
#(
    parameter int VID_W      = 6,
    parameter int RATIO_W    = 5,
    parameter int STEP_DWELL = 3,
    parameter int HOLD_MAX   = 2000,
    parameter int VID_INIT   = 20,
    parameter int RATIO_INIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VID_W-1:0]   req_vid,
    input  logic [RATIO_W-1:0] req_ratio,
    input  logic               pll_lock,
    output logic [VID_W-1:0]   vid_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               pll_relock,
    output logic               core_hold,
    output logic               snoop_block,
    output logic               busy,
    output logic               done
);

    localparam logic [RATIO_W-1:0] RINIT = RATIO_W'(RATIO_INIT);

    vfs_phase_e         ph_q;
    logic [VID_W-1:0]   tgt_vid_q;
    logic [RATIO_W-1:0] tgt_ratio_q;
    logic [RATIO_W-1:0] ratio_q;
    logic               clk_todo_q;
    logic               done_q;

    logic               idle;
    logic               pend_v;
    logic [VID_W-1:0]   pend_vid;
    logic [RATIO_W-1:0] pend_ratio;
    logic               src_v;
    logic [VID_W-1:0]   src_vid;
    logic [RATIO_W-1:0] src_ratio;
    logic [VID_W-1:0]   vid_now;
    logic               vid_at_tgt;
    logic               step_en;
    logic               relock_en;
    logic               relock_first;
    logic               hold_expired;
    logic               lock_ok;

    // Phase decodes feeding the sub-blocks.
    always_comb begin
        idle      = (ph_q == PH_IDLE);
        step_en   = (ph_q == PH_VOLT);
        relock_en = (ph_q == PH_CLK);
    end

    // Source of the next target: a fresh write beats a parked one.
    always_comb begin
        src_v     = req_valid || pend_v;
        src_vid   = req_valid ? req_vid   : pend_vid;
        src_ratio = req_valid ? req_ratio : pend_ratio;
    end

    // A lock counts only after the request cycle of a relock.
    always_comb begin
        lock_ok = pll_lock &&
                  (((ph_q == PH_CLK) && !relock_first) || (ph_q == PH_CLK_LATE));
    end

    vfs_req_hold #(
        .VID_W   (VID_W),
        .RATIO_W (RATIO_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (req_valid),
        .wr_vid     (req_vid),
        .wr_ratio   (req_ratio),
        .defer      (!idle),
        .take       (idle),
        .pend_v     (pend_v),
        .pend_vid   (pend_vid),
        .pend_ratio (pend_ratio)
    );

    vfs_vid_stepper #(
        .VID_W      (VID_W),
        .STEP_DWELL (STEP_DWELL),
        .VID_INIT   (VID_INIT)
    ) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (step_en),
        .tgt    (tgt_vid_q),
        .vid    (vid_now),
        .at_tgt (vid_at_tgt)
    );

    vfs_relock_timer #(
        .HOLD_MAX (HOLD_MAX)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (relock_en),
        .first   (relock_first),
        .expired (hold_expired)
    );

    // Phase sequencing, target capture and ratio update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_IDLE;
            tgt_vid_q   <= VID_W'(VID_INIT);
            tgt_ratio_q <= RINIT;
            ratio_q     <= RINIT;
            clk_todo_q  <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (src_v) begin
                        tgt_vid_q   <= src_vid;
                        tgt_ratio_q <= src_ratio;
                        if (src_vid == vid_now && src_ratio == ratio_q) begin
                            done_q <= 1'b1;
                        end else if (src_ratio > ratio_q) begin
                            ph_q       <= PH_VOLT;
                            clk_todo_q <= 1'b1;
                        end else if (src_ratio < ratio_q) begin
                            ph_q       <= PH_CLK;
                            ratio_q    <= src_ratio;
                            clk_todo_q <= 1'b0;
                        end else begin
                            ph_q       <= PH_VOLT;
                            clk_todo_q <= 1'b0;
                        end
                    end
                end
                PH_VOLT: begin
                    if (vid_at_tgt) begin
                        if (clk_todo_q) begin
                            ph_q       <= PH_CLK;
                            ratio_q    <= tgt_ratio_q;
                            clk_todo_q <= 1'b0;
                        end else begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                PH_CLK, PH_CLK_LATE: begin
                    if (lock_ok) begin
                        if (vid_at_tgt) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            ph_q <= PH_VOLT;
                        end
                    end else if (ph_q == PH_CLK && hold_expired) begin
                        ph_q <= PH_CLK_LATE;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        vid_out     = vid_now;
        ratio_out   = ratio_q;
        pll_relock  = relock_first;
        core_hold   = relock_en;
        snoop_block = relock_en;
        busy        = !idle;
        done        = done_q;
    end

endmodule

// File: rtl/vfs_seq_chk.sv
// Module: property checker for vfs_seq, attached by bind.
// Does:    checks step size, hold window bound, relock and done relations.
// Assumes: sees only the top-level ports; its counter mirrors no RTL state.
module vfs_seq_chk #(
    parameter int VID_W    = 6,
    parameter int RATIO_W  = 5,
    parameter int HOLD_MAX = 2000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VID_W-1:0]   vid_out,
    input logic [RATIO_W-1:0] ratio_out,
    input logic               pll_relock,
    input logic               core_hold,
    input logic               snoop_block,
    input logic               busy,
    input logic               done
);

    localparam int HW = $clog2(HOLD_MAX + 1) + 1;

    logic [HW-1:0] hold_run;

    // Consecutive cycles of hold seen before the current one (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !(core_hold || snoop_block)) begin
            hold_run <= '0;
        end else if (hold_run != {HW{1'b1}}) begin
            hold_run <= hold_run + 1'b1;
        end
    end

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out)) |->
        ((vid_out == $past(vid_out) + 1'b1) || (vid_out == $past(vid_out) - 1'b1)));

    a_r5_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold || snoop_block) |-> (hold_run < HW'(HOLD_MAX)));

    a_r5_hold_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        core_hold |-> busy);

    a_r1_vid_still_in_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && $past(core_hold)) |-> $stable(vid_out));

    a_r1_relock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pll_relock |-> (core_hold && snoop_block));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !core_hold));

    a_r8_no_motion_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> ($stable(vid_out) && $stable(ratio_out)));

endmodule

bind vfs_seq vfs_seq_chk #(
    .VID_W    (VID_W),
    .RATIO_W  (RATIO_W),
    .HOLD_MAX (HOLD_MAX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vid_out     (vid_out),
    .ratio_out   (ratio_out),
    .pll_relock  (pll_relock),
    .core_hold   (core_hold),
    .snoop_block (snoop_block),
    .busy        (busy),
    .done        (done)
);

// File: tb/vfs_seq_tb.sv
`timescale 1ns/1ps
module vfs_seq_tb_top;

    localparam int VW   = 6;
    localparam int RW   = 5;
    localparam int DW   = 3;
    localparam int MAXH = 2000;
    localparam int VR   = 20;
    localparam int RR   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [VW-1:0] req_vid = '0;
    logic [RW-1:0] req_ratio = '0;
    logic          pll_lock = 1'b0;
    logic [VW-1:0] vid_out;
    logic [RW-1:0] ratio_out;
    logic          pll_relock, core_hold, snoop_block, busy, done;

    always #2.5 clk = ~clk;

    vfs_seq #(
        .VID_W(VW), .RATIO_W(RW), .STEP_DWELL(DW), .HOLD_MAX(MAXH),
        .VID_INIT(VR), .RATIO_INIT(RR)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vid(req_vid),
        .req_ratio(req_ratio), .pll_lock(pll_lock), .vid_out(vid_out),
        .ratio_out(ratio_out), .pll_relock(pll_relock), .core_hold(core_hold),
        .snoop_block(snoop_block), .busy(busy), .done(done)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit fin = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ph, m_vid, m_ratio, m_tv, m_tr, m_vstart, m_vc, m_rc;
    bit m_clk, m_done, m_pv;
    int m_pvid, m_pr;

    task automatic m_after_lock();
        if (m_vid == m_tv) begin m_ph = 0; m_done = 1; end
        else begin m_ph = 1; m_vc = 0; end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_vid = VR; m_ratio = RR; m_tv = VR; m_tr = RR;
            m_vc = 0; m_rc = 0; m_clk = 0; m_done = 0; m_pv = 0; m_vstart = VR;
        end else begin
            m_done = 0;
            if (m_ph == 0) begin
                if (req_valid || m_pv) begin
                    int sv, sr;
                    sv = req_valid ? int'(req_vid) : m_pvid;
                    sr = req_valid ? int'(req_ratio) : m_pr;
                    m_pv = 0;
                    m_tv = sv; m_tr = sr; m_vstart = m_vid;
                    if (sv == m_vid && sr == m_ratio) m_done = 1;
                    else if (sr > m_ratio) begin m_ph = 1; m_clk = 1; m_vc = 0; end
                    else if (sr < m_ratio) begin m_ph = 2; m_ratio = sr; m_rc = 0; m_clk = 0; end
                    else begin m_ph = 1; m_clk = 0; m_vc = 0; end
                end
            end else begin
                if (req_valid) begin m_pv = 1; m_pvid = req_vid; m_pr = req_ratio; end
                case (m_ph)
                    1: begin
                        if (m_vid == m_tv) begin
                            if (m_clk) begin m_ph = 2; m_ratio = m_tr; m_rc = 0; m_clk = 0; end
                            else begin m_ph = 0; m_done = 1; end
                        end else if (m_vc == DW - 1) begin
                            m_vid = (m_tv > m_vid) ? m_vid + 1 : m_vid - 1;
                            m_vc = 0;
                        end else m_vc++;
                    end
                    2: begin
                        if (m_rc != 0 && pll_lock) m_after_lock();
                        else if (m_rc == MAXH - 1) m_ph = 3;
                        else m_rc++;
                    end
                    default: if (pll_lock) m_after_lock();
                endcase
            end
        end
    end

    // ---------------- PLL model ----------------
    int  lock_delay = 4;
    int  lock_cd = 0;
    bit  stray = 0;
    always @(negedge clk) begin
        pll_lock = stray;
        stray = 0;
        if (lock_cd > 0) begin
            lock_cd--;
            if (lock_cd == 0) pll_lock = 1'b1;
        end
        if (pll_relock) lock_cd = lock_delay;
    end

    // ---------------- per-cycle comparison and ordering monitors ----------------
    int prev_ratio = RR;
    int hold_len = 0;
    int hold_max_seen = 0;
    int relock_cnt = 0;
    int watch_ratio = -1;
    bit saw_watch = 0;
    int cyc = 0;

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(int'(vid_out) == m_vid, "R4 vid_out per cycle", vid_out, m_vid);
            chk(int'(ratio_out) == m_ratio, "R1/R2 ratio_out per cycle", ratio_out, m_ratio);
            chk(busy == (m_ph != 0), "R7 busy per cycle", busy, m_ph != 0);
            chk(core_hold == (m_ph == 2), "R5 core_hold per cycle", core_hold, m_ph == 2);
            chk(snoop_block == (m_ph == 2), "R5 snoop_block per cycle", snoop_block, m_ph == 2);
            chk(pll_relock == (m_ph == 2 && m_rc == 0), "R6 pll_relock per cycle",
                pll_relock, m_ph == 2 && m_rc == 0);
            chk(done == m_done, "R9 done per cycle", done, m_done);
            if (pll_relock) begin
                relock_cnt++;
                if (int'(ratio_out) > prev_ratio)
                    chk(int'(vid_out) == m_tv, "R1 vid at target before relock", vid_out, m_tv);
                else
                    chk(int'(vid_out) == m_vstart, "R2 vid unchanged at relock", vid_out, m_vstart);
            end
            if (done) begin
                chk(int'(vid_out) == m_tv && int'(ratio_out) == m_tr, "R9 done at target",
                    vid_out, m_tv);
                chk(!busy, "R9 done with busy low", busy, 0);
            end
            if (core_hold) hold_len++;
            else hold_len = 0;
            if (hold_len > hold_max_seen) hold_max_seen = hold_len;
            if (int'(ratio_out) == watch_ratio) saw_watch = 1;
            prev_ratio = ratio_out;
        end
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000 && !fin) begin
            fin = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input int v, input int r);
        @(negedge clk);
        req_valid = 1'b1; req_vid = VW'(v); req_ratio = RW'(r);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_ph != 0 || m_pv);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(int'(vid_out) == VR, "R10 vid reset", vid_out, VR);
        chk(int'(ratio_out) == RR, "R10 ratio reset", ratio_out, RR);
        chk(!busy && !done && !pll_relock && !core_hold && !snoop_block,
            "R10 flags reset", busy, 0);

        // R1 ratio up: voltage first
        relock_cnt = 0; lock_delay = 5;
        wr(24, 12); wait_idle();
        chk(int'(vid_out) == 24 && int'(ratio_out) == 12, "R1 final point", vid_out, 24);
        chk(relock_cnt == 1, "R1 one relock", relock_cnt, 1);

        // R2 ratio down: clock first
        relock_cnt = 0; lock_delay = 7;
        wr(18, 6); wait_idle();
        chk(int'(vid_out) == 18 && int'(ratio_out) == 6, "R2 final point", vid_out, 18);
        chk(relock_cnt == 1, "R2 one relock", relock_cnt, 1);

        // R3 same ratio, new code: no relock
        relock_cnt = 0;
        wr(21, 6); wait_idle();
        chk(relock_cnt == 0, "R3 no relock", relock_cnt, 0);
        chk(int'(vid_out) == 21, "R3 final code", vid_out, 21);

        // R8 equal target completes at once
        relock_cnt = 0;
        wr(21, 6);
        chk(done == 1'b1, "R8 done next cycle", done, 1);
        chk(!busy, "R8 never busy", busy, 0);
        repeat (3) @(negedge clk);
        chk(relock_cnt == 0 && int'(vid_out) == 21, "R8 no activity", relock_cnt, 0);

        // R7 deferral: newest wins, middle one never applied
        watch_ratio = 9; saw_watch = 0; lock_delay = 3;
        wr(25, 10);
        @(negedge clk);
        wr(23, 9);
        wr(19, 11);
        wait_idle();
        chk(int'(vid_out) == 19 && int'(ratio_out) == 11, "R7 newest deferred applied",
            vid_out, 19);
        chk(!saw_watch, "R7 overwritten request dropped", saw_watch, 0);
        watch_ratio = -1;

        // R6 stray locks while idle and while stepping
        stray = 1; repeat (2) @(negedge clk);
        stray = 1; repeat (2) @(negedge clk);
        chk(int'(vid_out) == 19 && int'(ratio_out) == 11 && !busy, "R6 idle lock ignored",
            vid_out, 19);
        wr(17, 11);
        stray = 1;
        wait_idle();
        chk(int'(vid_out) == 17 && int'(ratio_out) == 11, "R6 lock during stepping ignored",
            vid_out, 17);

        // R5 late lock: hold window capped, transition still completes
        hold_max_seen = 0; lock_delay = MAXH + 100;
        wr(18, 14); wait_idle();
        chk(hold_max_seen == MAXH, "R5 hold capped", hold_max_seen, MAXH);
        chk(int'(ratio_out) == 14 && int'(vid_out) == 18, "R5 completes after late lock",
            ratio_out, 14);

        // R1 ratio up with unchanged code
        lock_delay = 1; relock_cnt = 0;
        wr(18, 15); wait_idle();
        chk(int'(ratio_out) == 15 && relock_cnt == 1, "R1 ratio-only increase",
            ratio_out, 15);

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule